// File: doc/BRIEF.md
# Core Register File with Constant Generators

This block holds the sixteen 16-bit working registers of a small microcontroller core. Entry 0 is the program counter, entry 1 the stack pointer, entry 2 the status word and entry 3 a read-only constant source. The remaining twelve entries are interchangeable general-purpose storage. The core reads an operand through a source port, reads a second operand through a destination port, and writes one result per clock.

The source port carries a 2-bit addressing-mode field. For entries 2 and 3 this field selects a small fixed constant. The core can therefore use common immediates such as 0, 1, 2, 4, 8 and all-ones without fetching an extension word. The destination port never substitutes constants.

During synchronous reset the program counter loads the word that the core fetched from the reset vector location at address 0xFFFE. Afterwards a fetch strobe advances the counter by one 16-bit word per step.

Top module: `cpu_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, entry 0 loads `reset_vec` and every other entry clears to 0x0000.
- R2: When `pc_step` is high and entry 0 is not being written, entry 0 increases by 2 at the clock edge and wraps modulo 2^16.
- R3: A write to entry 0 takes priority over `pc_step`. Writes to entry 0 and to entry 1 store `wr_data` with bit 0 forced to 0.
- R4: For entries 0, 1 and 4 to 15, the source port returns the stored value for every `src_mode` code. The destination port returns the stored value for entries 0, 1, 2 and 4 to 15.
- R5: A write to any of entries 4 to 15 stores all 16 bits of `wr_data` unchanged.
- R6: When the source port reads entry 2, `src_mode` selects the result: 00 gives the stored value, 01 gives 0x0000, 10 gives 0x0004 and 11 gives 0x0008.
- R7: When the source port reads entry 3, `src_mode` selects the result: 00 gives 0x0000, 01 gives 0x0001, 10 gives 0x0002 and 11 gives 0xFFFF.
- R8: Writes to entry 3 have no effect. The destination port always returns 0x0000 for entry 3.
- R9: Both read ports are combinational and show the value held before the clock edge. A write becomes visible only after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec | input | 16 | Word from the reset vector location, loaded into the PC during reset |
| pc_step | input | 1 | Advance the PC by one word |
| src_sel | input | 4 | Source port register index |
| src_mode | input | 2 | Addressing-mode field for the source port |
| src_data | output | 16 | Source operand |
| dst_sel | input | 4 | Destination read port register index |
| dst_data | output | 16 | Destination operand |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 4 | Write register index |
| wr_data | input | 16 | Write data |

## Verification
The case that is hardest to reach from the ports is the conflict on entry 0, where an explicit write and a fetch step occur in the same cycle. The odd-valued write data that must lose bit 0 belongs to the same case. The stimulus first drives the counter to 0xFFFE so that the next step wraps. It then issues a write to entry 0 with an odd value while `pc_step` stays high. Every write in the sweep is also checked in its own cycle on both read ports. This confirms that the old value is still visible before the clock edge.

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int DATA_W = 16,
  parameter int NUM_REGS = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DATA_W-1:0]           reset_vec,
  input  logic                        pc_step,
  input  logic [$clog2(NUM_REGS)-1:0] src_sel,
  input  logic [1:0]                  src_mode,
  output logic [DATA_W-1:0]           src_data,
  input  logic [$clog2(NUM_REGS)-1:0] dst_sel,
  output logic [DATA_W-1:0]           dst_data,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_sel,
  input  logic [DATA_W-1:0]           wr_data
);
  localparam int ADDR_W = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] PC_IDX = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] SP_IDX = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SR_IDX = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] CG_IDX = ADDR_W'(3);
  localparam logic [DATA_W-1:0] PC_INC = DATA_W'(2);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] sr_const, cg_const, wr_word;
  logic              wr_pc, wr_even;

  assign wr_pc   = wr_en && (wr_sel == PC_IDX);
  assign wr_even = (wr_sel == PC_IDX) || (wr_sel == SP_IDX);
  assign wr_word = wr_even ? {wr_data[DATA_W-1:1], 1'b0} : wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_REGS; k++) regs[k] <= '0;
      regs[PC_IDX] <= reset_vec;
    end else begin
      if (wr_en && wr_sel != CG_IDX) regs[wr_sel] <= wr_word;
      if (pc_step && !wr_pc) regs[PC_IDX] <= regs[PC_IDX] + PC_INC;
    end
  end

  always_comb begin
    unique case (src_mode)
      2'b00: sr_const = regs[SR_IDX];
      2'b01: sr_const = '0;
      2'b10: sr_const = DATA_W'(4);
      default: sr_const = DATA_W'(8);
    endcase
    unique case (src_mode)
      2'b00: cg_const = '0;
      2'b01: cg_const = DATA_W'(1);
      2'b10: cg_const = DATA_W'(2);
      default: cg_const = '1;
    endcase
  end

  assign src_data = (src_sel == SR_IDX) ? sr_const :
                    (src_sel == CG_IDX) ? cg_const : regs[src_sel];
  assign dst_data = (dst_sel == CG_IDX) ? '0 : regs[dst_sel];

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (pc_step && !wr_pc) |=> regs[PC_IDX] == $past(regs[PC_IDX]) + PC_INC); // R2
  AST_PC_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_pc |=> regs[PC_IDX] == {$past(wr_data[DATA_W-1:1]), 1'b0}); // R3
  AST_SP_EVEN: assert property (@(posedge clk) disable iff (rst)
    regs[SP_IDX][0] == 1'b0); // R3
  AST_CG_DST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dst_sel == CG_IDX) |-> dst_data == '0); // R8
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_sel == SP_IDX) |=> $stable(regs[SP_IDX])); // R9
  AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_sel == SR_IDX) |=> $stable(regs[SR_IDX])); // R6
endmodule

// File: tb/cpu_regfile_bench.sv
module cpu_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VEC = 16'hF800;

  logic clk = 0, rst = 1, pc_step = 0, wr_en = 0;
  logic [15:0] reset_vec = VEC, wr_data = '0;
  logic [3:0] src_sel = '0, dst_sel = '0, wr_sel = '0;
  logic [1:0] src_mode = '0;
  logic [15:0] src_data, dst_data;
  logic [15:0] model [16];
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_regfile u_cpu_regfile (
    .clk(clk), .rst(rst), .reset_vec(reset_vec), .pc_step(pc_step),
    .src_sel(src_sel), .src_mode(src_mode), .src_data(src_data),
    .dst_sel(dst_sel), .dst_data(dst_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] src_exp(int k, int m);
    if (k == 2) begin
      case (m) 0: return model[2]; 1: return 16'h0000; 2: return 16'h0004; default: return 16'h0008; endcase
    end else if (k == 3) begin
      case (m) 0: return 16'h0000; 1: return 16'h0001; 2: return 16'h0002; default: return 16'hFFFF; endcase
    end
    return model[k];
  endfunction

  task automatic read_all(string req);
    for (int k = 0; k < 16; k++) begin
      for (int m = 0; m < 4; m++) begin
        src_sel = 4'(k); src_mode = 2'(m); dst_sel = 4'(k);
        #1;
        check(k == 2 ? "R6" : (k == 3 ? "R7" : req), src_data, src_exp(k, m));
        check(k == 3 ? "R8" : "R4", dst_data, (k == 3) ? 16'h0 : model[k]);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) model[k] = '0;
    model[0] = VEC;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    read_all("R1");

    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 16; k++) begin
        logic [15:0] p;
        p = 16'hA5C3 ^ 16'(k * 16'h1357);
        if (pass == 1) p = ~p;
        @(negedge clk);
        wr_en = 1; wr_sel = 4'(k); wr_data = p;
        src_sel = 4'(k); src_mode = 2'b00; dst_sel = 4'(k);
        #1;
        check("R9", src_data, src_exp(k, 0));
        check("R9", dst_data, (k == 3) ? 16'h0 : model[k]);
        @(posedge clk);
        if (k == 0 || k == 1) model[k] = {p[15:1], 1'b0};
        else if (k != 3) model[k] = p;
        @(negedge clk); wr_en = 0;
        read_all(k >= 4 ? "R5" : (k < 2 ? "R3" : "R4"));
      end
    end

    @(negedge clk); wr_en = 1; wr_sel = 4'd0; wr_data = 16'h0100;
    @(negedge clk); wr_en = 0; pc_step = 1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk); src_sel = 4'd0; src_mode = 2'(i); #1;
      check("R2", src_data, 16'(16'h0100 + 2 * i));
    end
    pc_step = 0;

    @(negedge clk); wr_en = 1; wr_sel = 4'd0; wr_data = 16'hFFFE;
    @(negedge clk); wr_en = 0; pc_step = 1;
    @(negedge clk); pc_step = 0; src_sel = 4'd0; #1;
    check("R2", src_data, 16'h0000);

    @(negedge clk); wr_en = 1; wr_sel = 4'd0; wr_data = 16'h1235; pc_step = 1;
    @(negedge clk); wr_en = 0; pc_step = 0; src_sel = 4'd0; dst_sel = 4'd0; #1;
    check("R3", src_data, 16'h1234);
    check("R3", dst_data, 16'h1234);

    @(negedge clk); wr_en = 1; wr_sel = 4'd1; wr_data = 16'h0281; pc_step = 1;
    @(negedge clk); wr_en = 0; pc_step = 0; src_sel = 4'd1; src_mode = 2'b11; #1;
    check("R3", src_data, 16'h0280);
    src_sel = 4'd0; #1;
    check("R2", src_data, 16'h1236);

    @(negedge clk); rst = 1; reset_vec = 16'hC002;
    @(negedge clk); rst = 0;
    for (int k = 0; k < 16; k++) model[k] = '0;
    model[0] = 16'hC002;
    read_all("R1");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule